// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of general-purpose input pins and raises one level-sensitive interrupt when any pin has seen its configured trigger condition. Each pin has its own trigger. It can fire on a rising edge, a falling edge, either edge, a high level or a low level. The trigger is chosen by three configuration bits per pin: edge-select, polarity and either-edge.

Software reaches the block through a single-cycle register port with no wait states. Reads are combinational from the current register state. Writes take effect at the next clock edge.

Masking is controlled through two strobe registers. One sets mask bits and the other clears them, and the resulting mask can be read back. Detection runs whether or not a pin is masked. An event captured while a pin is masked waits in the status register and raises the interrupt as soon as the pin is unmasked. Status bits are cleared by writing ones to them. The pins are expected to be synchronous to the clock already.

Top module: `gpio_irq_det`

## Requirements
- R1: A write to the unmask strobe (word 5) clears the mask bit of every pin whose data bit is 1. Zero data bits leave their mask bits unchanged, and the strobe reads as 0.
- R2: A write to the mask strobe (word 6) sets the mask bit of every pin whose data bit is 1. A single all-ones write masks the whole bank. The strobe reads as 0.
- R3: The mask (word 4) is read-only, and a write to word 4 leaves it unchanged.
- R4: Writing 1 to a bit of the status register (word 3) clears that bit unless a new event sets it in the same cycle. Zero bits have no effect.
- R5: With edge-select=1 and either-edge=0, polarity 1 sets status on a rising edge only and polarity 0 on a falling edge only. Config words: edge-select is word 0, polarity word 1, either-edge word 2.
- R6: With edge-select=1 and either-edge=1, both rising and falling edges set status, whatever the polarity bit is.
- R7: With edge-select=0, status is set on every cycle the pin sits at the level chosen by polarity (1 = high, 0 = low), whatever the either-edge bit is. A clear therefore does not stick while that level lasts.
- R8: Events are latched while a pin is masked. Unmasking a pin with pending status raises irq_o.
- R9: irq_o is high exactly when some status bit is set whose mask bit is clear.
- R10: After reset every mask bit is 1, every status bit is 0, all configuration bits are 0, and irq_o is low.
- R11: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R12: The edge-select, polarity and either-edge words read back what was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Synchronised pin levels |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Register word select |
| wdata_i | input | NUM_PINS | Write data, one bit per pin |
| rdata_o | output | NUM_PINS | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt: unmasked pending status |

## Verification
The bench builds the block at its default width of 32 pins, so every bit position of the 32-bit mask and status words is exercised, including the all-ones mask write. Random pin levels, configuration and strobes give a wide spread of mixed trigger modes across the bank within one run. Directed steps on pins 0 to 2 reach the same-cycle clear-versus-event case and the levels that are re-set while held.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EDGE = 3'd0,
    SEL_POL  = 3'd1,
    SEL_ANY  = 3'd2,
    SEL_STAT = 3'd3,
    SEL_MASK = 3'd4,
    SEL_UNM  = 3'd5,
    SEL_MSK  = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  // Trigger decode for one pin.
  function automatic logic trig_hit(input logic edge_sel, input logic pol,
                                    input logic any, input logic cur,
                                    input logic prv);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (edge_sel) begin
      if (any) trig_hit = rise | fall;
      else     trig_hit = pol ? rise : fall;
    end else begin
      trig_hit = pol ? cur : ~cur;
    end
  endfunction
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] edge_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] any_o,
  output logic [NUM_PINS-1:0] mask_o
);
  logic [NUM_PINS-1:0] edge_q, pol_q, any_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      mask_q <= '1;
    end else if (wr_i) begin
      unique case (sel_i)
        SEL_EDGE: edge_q <= wdata_i;
        SEL_POL:  pol_q  <= wdata_i;
        SEL_ANY:  any_q  <= wdata_i;
        SEL_UNM:  mask_q <= mask_q & ~wdata_i;
        SEL_MSK:  mask_q <= mask_q | wdata_i;
        default: ;
      endcase
    end
  end

  assign edge_o = edge_q;
  assign pol_o  = pol_q;
  assign any_o  = any_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_i,
  input  logic pol_i,
  input  logic any_i,
  input  logic clr_i,
  output logic stat_o
);
  logic prev_q, stat_q, hit;

  assign hit = trig_hit(edge_i, pol_i, any_i, pin_i, prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      // new event takes priority over clear
      stat_q <= hit | (stat_q & ~clr_i);
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] edge_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] any_i,
  input  logic [NUM_PINS-1:0] stat_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      SEL_EDGE: rdata_o = edge_i;
      SEL_POL:  rdata_o = pol_i;
      SEL_ANY:  rdata_o = any_i;
      SEL_STAT: rdata_o = stat_i;
      SEL_MASK: rdata_o = mask_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic                irq_o
);
  reg_sel_e            sel;
  logic                wr;
  logic [NUM_PINS-1:0] edge_w, pol_w, any_w, mask_w, status_w, clr_w;

  assign sel   = reg_sel_e'(addr_i);
  assign wr    = req_i & we_i;
  assign clr_w = (wr && sel == SEL_STAT) ? wdata_i : '0;

  gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .edge_o  (edge_w),
    .pol_o   (pol_w),
    .any_o   (any_w),
    .mask_o  (mask_w)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins_i[g]),
      .edge_i (edge_w[g]),
      .pol_i  (pol_w[g]),
      .any_i  (any_w[g]),
      .clr_i  (clr_w[g]),
      .stat_o (status_w[g])
    );
  end

  gpio_irq_rdmux #(.NUM_PINS(NUM_PINS)) u_rd (
    .sel_i   (sel),
    .edge_i  (edge_w),
    .pol_i   (pol_w),
    .any_i   (any_w),
    .stat_i  (status_w),
    .mask_i  (mask_w),
    .rdata_o (rdata_o)
  );

  assign irq_o = |(status_w & ~mask_w);
endmodule

// File: rtl/gpio_irq_det_chk.sv
module gpio_irq_det_chk #(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pins_i,
  input logic                req_i,
  input logic                we_i,
  input logic [2:0]          addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] mask_w,
  input logic [NUM_PINS-1:0] status_w,
  input logic [NUM_PINS-1:0] edge_w,
  input logic [NUM_PINS-1:0] pol_w,
  input logic [NUM_PINS-1:0] any_w
);
  logic                wr_unm, wr_msk, wr_mro, wr_clr;
  logic [NUM_PINS-1:0] clr_bits;

  assign wr_unm   = req_i && we_i && addr_i == 3'd5;
  assign wr_msk   = req_i && we_i && addr_i == 3'd6;
  assign wr_mro   = req_i && we_i && addr_i == 3'd4;
  assign wr_clr   = req_i && we_i && addr_i == 3'd3;
  assign clr_bits = wr_clr ? wdata_i : '0;

  a_r1_unmask_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_unm |=> ((mask_w & $past(wdata_i)) == '0));

  a_r2_mask_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_msk |=> ((mask_w & $past(wdata_i)) == $past(wdata_i)));

  a_r3_mask_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mro |=> (mask_w == $past(mask_w)));

  a_r4_status_drops_only_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_w) & ~$past(clr_bits)) & ~status_w) == '0));

  a_r5_rise_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pins_i) & ~$past(pins_i, 2) & $past(edge_w & pol_w & ~any_w))
               & ~status_w) == '0));

  a_r7_level_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pins_i) & $past(~edge_w & pol_w)) & ~status_w) == '0));

  a_r9_irq_needs_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_w != '1 && status_w != '0));
endmodule

bind gpio_irq_det gpio_irq_det_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pins_i   (pins_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .mask_w   (mask_w),
  .status_w (status_w),
  .edge_w   (edge_w),
  .pol_w    (pol_w),
  .any_w    (any_w)
);

// File: tb/gpio_irq_det_tb_top.sv
module gpio_irq_det_tb_top;
  localparam int unsigned N = 32;
  localparam logic [N-1:0] ONES = '1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] pins_i = '1;
  logic         req_i = 1'b0;
  logic         we_i = 1'b0;
  logic [2:0]   addr_i = '0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic         irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  gpio_irq_det #(.NUM_PINS(N)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  // bench model built from the requirements
  logic [N-1:0] m_edge, m_pol, m_any, m_mask, m_stat, m_prev;

  function automatic logic [N-1:0] exp_event(logic [N-1:0] t, p, a, cur, prv);
    logic [N-1:0] rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    return (t & a & (rise | fall)) | (t & ~a & p & rise) | (t & ~a & ~p & fall)
         | (~t & p & cur) | (~t & ~p & ~cur);
  endfunction

  function automatic logic [N-1:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return m_edge;
      3'd1: return m_pol;
      3'd2: return m_any;
      3'd3: return m_stat;
      3'd4: return m_mask;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_edge <= '0; m_pol <= '0; m_any <= '0; m_mask <= '1; m_stat <= '0; m_prev <= '0;
    end else begin
      logic [N-1:0] clr;
      clr = (req_i && we_i && addr_i == 3'd3) ? wdata_i : '0;
      m_stat <= exp_event(m_edge, m_pol, m_any, pins_i, m_prev) | (m_stat & ~clr);
      m_prev <= pins_i;
      if (req_i && we_i) begin
        case (addr_i)
          3'd0: m_edge <= wdata_i;
          3'd1: m_pol  <= wdata_i;
          3'd2: m_any  <= wdata_i;
          3'd5: m_mask <= m_mask & ~wdata_i;
          3'd6: m_mask <= m_mask | wdata_i;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #2 d = rdata_o;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [N-1:0] exp);
    logic [N-1:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic set_pin(int idx, logic v);
    @(negedge clk_i);
    pins_i[idx] = v;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'h5eed_1234));

    // R10 reset state, read while held in reset
    #35;
    addr_i = 3'd4; #1 check("R10 mask", rdata_o, ONES);
    addr_i = 3'd3; #1 check("R10 status", rdata_o, '0);
    addr_i = 3'd0; #1 check("R10 edge", rdata_o, '0);
    addr_i = 3'd1; #1 check("R10 pol", rdata_o, '0);
    addr_i = 3'd2; #1 check("R10 any", rdata_o, '0);
    check("R10 irq", {{(N-1){1'b0}}, irq_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R3 mask word is read-only
    wr(3'd4, '0);
    rd_chk("R3 mask unchanged", 3'd4, ONES);

    // R5 rising edge on pin 0
    wr(3'd0, 32'h1); wr(3'd1, 32'h1);
    set_pin(0, 1'b0);
    rd_chk("R5 fall ignored in rise mode", 3'd3, '0);
    set_pin(0, 1'b1);
    rd_chk("R5 rise sets", 3'd3, 32'h1);
    // R8 latched while masked, irq after unmask
    check("R8 masked no irq", {{(N-1){1'b0}}, irq_o}, '0);
    wr(3'd5, 32'h1);
    check("R8 unmask raises irq", {{(N-1){1'b0}}, irq_o}, 32'h1);
    rd_chk("R1 unmask bit0", 3'd5, '0);
    rd_chk("R1 mask value", 3'd4, ~32'h1);
    // R4 clear
    wr(3'd3, 32'h1);
    rd_chk("R4 clear", 3'd3, '0);
    check("R9 irq low when nothing pending", {{(N-1){1'b0}}, irq_o}, '0);
    // R5 falling mode
    wr(3'd1, 32'h0);
    set_pin(0, 1'b0);
    rd_chk("R5 fall sets", 3'd3, 32'h1);
    wr(3'd3, 32'h1);

    // R6 both edges on pin 1, polarity bit set to show it is ignored
    wr(3'd0, 32'h3); wr(3'd2, 32'h2); wr(3'd1, 32'h2);
    set_pin(1, 1'b0);
    rd_chk("R6 fall sets", 3'd3, 32'h2);
    wr(3'd3, 32'h2);
    set_pin(1, 1'b1);
    rd_chk("R6 rise sets", 3'd3, 32'h2);
    wr(3'd3, 32'h2);

    // R7 level high on pin 2 with any-edge bit set (ignored)
    wr(3'd1, 32'h6); wr(3'd2, 32'h6);
    rd_chk("R7 high level sets", 3'd3, 32'h4);
    wr(3'd3, 32'h4);
    rd_chk("R7 clear does not stick", 3'd3, 32'h4);
    set_pin(2, 1'b0);
    wr(3'd3, 32'h4);
    rd_chk("R7 cleared after level drops", 3'd3, '0);
    wr(3'd1, 32'h2);
    rd_chk("R7 low level sets", 3'd3, 32'h4);

    // R11 event and clear in the same cycle on pin 0 (rising mode)
    wr(3'd1, 32'h3);
    @(negedge clk_i);
    pins_i[0] = 1'b1; req_i = 1'b1; we_i = 1'b1; addr_i = 3'd3; wdata_i = 32'h1;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    rd(3'd3, d);
    check("R11 event wins", d & 32'h1, 32'h1);

    // R2 all-ones mask, R1 zero bits ignored
    wr(3'd5, 32'hF0);
    wr(3'd6, ONES);
    rd_chk("R2 all masked", 3'd4, ONES);
    check("R2 irq low", {{(N-1){1'b0}}, irq_o}, '0);
    rd_chk("R2 strobe reads zero", 3'd6, '0);
    wr(3'd5, '0);
    rd_chk("R1 zero write no effect", 3'd4, ONES);

    // R12 readback
    for (int i = 0; i < 3; i++) begin
      logic [N-1:0] v;
      v = $urandom;
      wr(3'(i), v);
      rd_chk("R12 readback", 3'(i), v);
    end

    // random phase against the model
    for (int it = 0; it < 600; it++) begin
      @(negedge clk_i);
      req_i = 1'b0; we_i = 1'b0;
      pins_i = $urandom;
      if ($urandom_range(0, 1) == 1) begin
        req_i = 1'b1; we_i = 1'b1;
        addr_i = 3'($urandom_range(0, 7));
        wdata_i = $urandom;
      end
      @(negedge clk_i);
      req_i = 1'b0; we_i = 1'b0;
      addr_i = 3'($urandom_range(0, 7));
      #2;
      check("R9 random readback", rdata_o, exp_read(addr_i));
      check("R9 random irq", {{(N-1){1'b0}}, irq_o},
            {{(N-1){1'b0}}, |(m_stat & ~m_mask)});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule